// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Front End

This block models the digital front end of an 8-bit asynchronous NAND flash die, sampled on a fast system clock. It synchronises the host strobes, latches command bytes and address bytes on write-strobe rising edges, and keeps a column pointer into the page. The column pointer walks through a small on-die page buffer. Data bytes written while a program is being set up land in that buffer. Read-strobe falling edges return bytes from it.

An accepted confirm command hands an operation request to the array (kind plus row address). It also holds the ready/busy flag low for a programmable number of clocks. The array itself, its timing and its error correction are outside the block. The page is 2048 data bytes plus 64 spare bytes. The row address covers 64 pages in each of 2048 blocks.

Top module: `nand_fe_top`

## Requirements
- R1: A byte on `io_in` is taken as a command on a synchronised `we_n` rising edge with `cle` high, `ale` low and `ce_n` low. A confirm (0x30 read, 0x10 program, 0xD0 erase) starts an operation only when the matching setup (0x00, 0x80, 0x60) was the previous command. The start is reported as a one-clock `op_valid` pulse with `op_kind` 0 = read, 1 = program, 2 = erase.
- R2: After setup 0x00 or 0x80, address bytes (`ale` high, `cle` low) are taken in this order: column low byte, column high byte (only bits 3:0 kept), then row bits 7:0, row bits 15:8, and row bit 16 (only bit 0 kept). After 0x60 only the three row bytes are taken. Further address bytes are ignored. `op_row` carries the assembled row.
- R3: A column address above 2111 is loaded as 2111.
- R4: During program setup, a data byte (`cle` and `ale` low) is stored at the current column, and the column then advances by one. The column does not advance past 2111.
- R5: Each synchronised `re_n` falling edge places the byte at the current column on `io_out` and advances the column by one, stopping at 2111.
- R6: `io_oe` is high only while `ce_n` is low and the synchronised `re_n` is low.
- R7: After an accepted confirm, `rb` is low for exactly `busy_len` clocks; with `busy_len` = 0 it stays high.
- R8: While `wp_n` is low, program and erase confirms start nothing and leave `rb` high. Read confirms are unaffected.
- R9: With `ce_n` high, strobes are ignored. Raising `ce_n` during busy does not shorten it.
- R10: While busy, every strobe is ignored except command 0xFF. That command ends busy at once and clears the setup state.
- R11: After reset, `rb` is high, and `io_oe` and `op_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command byte qualifier |
| ale | input | 1 | Address byte qualifier |
| we_n | input | 1 | Write strobe, latches on rising edge |
| re_n | input | 1 | Read strobe, serves data on falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte from the host |
| busy_len | input | 16 | Busy duration in clocks |
| io_out | output | 8 | Byte to the host |
| io_oe | output | 1 | Drive enable for `io_out` |
| rb | output | 1 | Ready (high) / busy (low) |
| op_valid | output | 1 | One-clock operation start pulse |
| op_kind | output | 2 | 0 read, 1 program, 2 erase |
| op_row | output | 17 | Row address of the started operation |

## Verification
The interesting coincidences are a busy countdown that is already running when a new strobe arrives, and a column pointer that reaches its last position while the host keeps stepping. Address bytes and read strobes are fired in the middle of a busy window. The bench then checks that the busy length and the later read data match a behavioural model that dropped those strobes. A reset command is also issued mid-busy, and `rb` must recover long before the programmed length. Writes and reads are pushed past column 2111, and the repeated bytes are compared with the model's saturating pointer.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_PROG,
        PH_ERASE
    } phase_e;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

endpackage

// File: rtl/nand_fe_sync.sv
module nand_fe_sync #(
    parameter int           N    = 4,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = raw;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: IDLE, s2: IDLE, s3: IDLE};
        else        q <= d;
    end

    assign lvl = q.s2;

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] =  q.s2[i] & ~q.s3[i];
        assign fall[i] = ~q.s2[i] &  q.s3[i];
    end

endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr #(
    parameter int COL_W   = 12,
    parameter int ROW_W   = 17,
    parameter int COL_MAX = 2111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_idx,
    input  logic [2:0]       idx_val,
    input  logic             byte_we,
    input  logic [7:0]       byte_in,
    input  logic             col_inc,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    localparam logic [COL_W-1:0] COL_LAST    = COL_W'(COL_MAX);
    localparam logic [15:0]      COL_MASK    = 16'((32'd1 << COL_W) - 32'd1);
    localparam logic [23:0]      ROW_MASK    = 24'((32'd1 << ROW_W) - 32'd1);
    localparam logic [7:0]       COL_HI_MASK = COL_MASK[15:8];
    localparam logic [7:0]       ROW_HI_MASK = ROW_MASK[23:16];
    localparam logic [2:0]       IDX_DONE    = 3'd5;

    typedef struct packed {
        logic [15:0]      asm_col;
        logic [COL_W-1:0] col;
        logic [23:0]      row_raw;
        logic [2:0]       idx;
    } addr_t;

    addr_t d, q;

    function automatic logic [COL_W-1:0] clamp_col(input logic [15:0] v);
        if (v > 16'(COL_MAX)) return COL_LAST;
        return v[COL_W-1:0];
    endfunction

    always_comb begin
        d = q;
        if (load_idx) begin
            d.idx = idx_val;
        end else if (byte_we && q.idx < IDX_DONE) begin
            case (q.idx)
                3'd0:    d.asm_col[7:0]   = byte_in;
                3'd1:    d.asm_col[15:8]  = byte_in & COL_HI_MASK;
                3'd2:    d.row_raw[7:0]   = byte_in;
                3'd3:    d.row_raw[15:8]  = byte_in;
                default: d.row_raw[23:16] = byte_in & ROW_HI_MASK;
            endcase
            if (q.idx < 3'd2) d.col = clamp_col(d.asm_col);
            d.idx = q.idx + 3'd1;
        end
        if (col_inc && q.col < COL_LAST) d.col = q.col + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{asm_col: '0, col: '0, row_raw: '0, idx: IDX_DONE};
        else        q <= d;
    end

    assign col = q.col;
    assign row = q.row_raw[ROW_W-1:0];

    // R3: the pointer never leaves the page
    a_r3_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        q.col <= COL_LAST);

    // R2: address byte index stays within the five-byte sequence
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_DONE);

    // R4, R5: a step at the last column leaves it unchanged
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (col_inc && !byte_we && !load_idx && q.col == COL_LAST) |=> q.col == COL_LAST);

endmodule

// File: rtl/nand_fe_busy.sv
module nand_fe_busy #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } busy_t;

    busy_t d, q;

    always_comb begin
        d = q;
        if (abort)              d.cnt = '0;
        else if (start)         d.cnt = len;
        else if (q.cnt != '0)   d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0};
        else        q <= d;
    end

    assign busy = (q.cnt != '0);

    // R7: an undisturbed countdown loses exactly one per clock
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && !start && !abort) |=> (q.cnt == $past(q.cnt - CNT_W'(1))));

    // R10: the reset command empties the timer
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: rtl/nand_fe_pagebuf.sv
module nand_fe_pagebuf #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/nand_fe_top.sv
module nand_fe_top
    import nand_fe_pkg::*;
#(
    parameter int DATA_BYTES      = 2048,
    parameter int SPARE_BYTES     = 64,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCKS          = 2048,
    parameter int BUF_DEPTH       = 64,
    parameter int CNT_W           = 16,
    parameter int ROW_W           = $clog2(PAGES_PER_BLOCK * BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic             wp_n,
    input  logic [7:0]       io_in,
    input  logic [CNT_W-1:0] busy_len,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rb,
    output logic             op_valid,
    output logic [1:0]       op_kind,
    output logic [ROW_W-1:0] op_row
);
    localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
    localparam int COL_MAX    = PAGE_BYTES - 1;
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int BUF_AW     = $clog2(BUF_DEPTH);

    // strobe lanes: 0 write, 1 read, 2 command qualifier, 3 address qualifier
    logic [3:0] s_lvl, s_rise, s_fall;
    logic       unused_edges;

    nand_fe_sync #(.N(4), .IDLE(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({ale, cle, re_n, we_n}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign unused_edges = ^{s_rise[3:1], s_fall[3:2], s_fall[0], s_lvl[0]};

    typedef struct packed {
        phase_e           phase;
        logic [7:0]       dout;
        logic             opv;
        op_kind_e         kind;
        logic [ROW_W-1:0] orow;
    } fe_t;

    fe_t d, q;

    logic             sel, busy, ready;
    logic             cmd_stb, addr_we, buf_we, rd_stb, col_inc;
    logic             load_idx, busy_start, busy_abort;
    logic [2:0]       idx_val;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [7:0]       rdata;

    assign sel     = ~ce_n;
    assign ready   = ~busy;
    assign cmd_stb = sel & s_rise[0] & s_lvl[2] & ~s_lvl[3];
    assign addr_we = sel & s_rise[0] & s_lvl[3] & ~s_lvl[2] & ready;
    assign buf_we  = sel & s_rise[0] & ~s_lvl[2] & ~s_lvl[3] & ready & (q.phase == PH_PROG);
    assign rd_stb  = sel & s_fall[1] & ready;
    assign col_inc = buf_we | rd_stb;

    always_comb begin
        d          = q;
        d.opv      = 1'b0;
        load_idx   = 1'b0;
        idx_val    = 3'd5;
        busy_start = 1'b0;
        busy_abort = 1'b0;

        if (cmd_stb && io_in == CMD_RESET) begin
            busy_abort = 1'b1;
            d.phase    = PH_IDLE;
            load_idx   = 1'b1;
        end else if (cmd_stb && ready) begin
            d.phase = PH_IDLE;
            case (io_in)
                CMD_RD_SETUP: begin
                    d.phase  = PH_READ;
                    load_idx = 1'b1;
                    idx_val  = 3'd0;
                end
                CMD_PG_SETUP: begin
                    d.phase  = PH_PROG;
                    load_idx = 1'b1;
                    idx_val  = 3'd0;
                end
                CMD_ER_SETUP: begin
                    d.phase  = PH_ERASE;
                    load_idx = 1'b1;
                    idx_val  = 3'd2;
                end
                CMD_RD_GO: begin
                    if (q.phase == PH_READ) begin
                        busy_start = 1'b1;
                        d.kind     = OP_READ;
                    end
                end
                CMD_PG_GO: begin
                    if (q.phase == PH_PROG && wp_n) begin
                        busy_start = 1'b1;
                        d.kind     = OP_PROG;
                    end
                end
                CMD_ER_GO: begin
                    if (q.phase == PH_ERASE && wp_n) begin
                        busy_start = 1'b1;
                        d.kind     = OP_ERASE;
                    end
                end
                default: ;
            endcase
            if (busy_start) begin
                d.opv  = 1'b1;
                d.orow = row;
            end
        end

        if (rd_stb) d.dout = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, dout: '0, opv: 1'b0, kind: OP_READ, orow: '0};
        else        q <= d;
    end

    nand_fe_addr #(.COL_W(COL_W), .ROW_W(ROW_W), .COL_MAX(COL_MAX)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_idx(load_idx),
        .idx_val (idx_val),
        .byte_we (addr_we),
        .byte_in (io_in),
        .col_inc (col_inc),
        .col     (col),
        .row     (row)
    );

    nand_fe_busy #(.CNT_W(CNT_W)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(busy_start),
        .abort(busy_abort),
        .len  (busy_len),
        .busy (busy)
    );

    nand_fe_pagebuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(col[BUF_AW-1:0]),
        .wdata(io_in),
        .raddr(col[BUF_AW-1:0]),
        .rdata(rdata)
    );

    assign io_out   = q.dout;
    assign io_oe    = sel & ~s_lvl[1];
    assign rb       = ready;
    assign op_valid = q.opv;
    assign op_kind  = q.kind;
    assign op_row   = q.orow;

    // R1, R10: an operation only starts from the ready state
    a_r1_op_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(ready));

    // R8: program and erase starts require write protect released
    a_r8_wp_guards: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'd0) |-> $past(wp_n));

    // R7: a nonzero length makes the device busy alongside the start pulse
    a_r7_busy_with_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy_len) != '0) |-> !rb);

endmodule

// File: tb/tb_nand_fe_top.sv
module tb_nand_fe_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0]  io_in = '0;
    logic [15:0] busy_len = 16'd20;
    logic [7:0]  io_out;
    logic        io_oe, rb, op_valid;
    logic [1:0]  op_kind;
    logic [16:0] op_row;

    nand_fe_top dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .busy_len(busy_len),
        .io_out(io_out), .io_oe(io_oe), .rb(rb), .op_valid(op_valid),
        .op_kind(op_kind), .op_row(op_row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural reference state
    int m_col = 0, m_idx = 5, m_phase = 0, m_lo = 0, m_hi = 0, m_row = 0;
    bit m_busy = 0;
    int m_buf [64];
    int exp_kind [$];
    int exp_row [$];
    int exp_low = 0, low_cnt = 0;
    logic re_a = 1'b1, re_b = 1'b1;

    function automatic int clamp(int v);
        return (v > 2111) ? 2111 : v;
    endfunction

    task automatic strobe(logic c, logic a, logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b;
        cyc(2); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(4);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic push_op(int k);
        exp_kind.push_back(k);
        exp_row.push_back(m_row);
        exp_low = busy_len;
        m_busy  = (busy_len != 0);
    endtask

    task automatic host_cmd(logic [7:0] b);
        if (b != 8'hFF) begin low_cnt = 0; exp_low = 0; end
        if (!ce_n) begin
            if (b == 8'hFF) begin
                m_phase = 0; m_idx = 5;
            end else if (!m_busy) begin
                int nxt = 0;
                case (b)
                    8'h00: begin nxt = 1; m_idx = 0; end
                    8'h80: begin nxt = 2; m_idx = 0; end
                    8'h60: begin nxt = 3; m_idx = 2; end
                    8'h30: if (m_phase == 1) push_op(0);
                    8'h10: if (m_phase == 2 && wp_n) push_op(1);
                    8'hD0: if (m_phase == 3 && wp_n) push_op(2);
                    default: ;
                endcase
                m_phase = nxt;
            end
        end
        strobe(1'b1, 1'b0, b);
    endtask

    task automatic host_addr(logic [7:0] b);
        if (!ce_n && !m_busy && m_idx < 5) begin
            case (m_idx)
                0: begin m_lo = b; m_col = clamp(m_hi * 256 + m_lo); end
                1: begin m_hi = b & 8'h0F; m_col = clamp(m_hi * 256 + m_lo); end
                2: m_row = (m_row & 'h1FF00) | b;
                3: m_row = (m_row & 'h100FF) | (int'(b) << 8);
                default: m_row = (m_row & 'h0FFFF) | ((b & 1) << 16);
            endcase
            m_idx++;
        end
        strobe(1'b0, 1'b1, b);
    endtask

    task automatic host_addr5(logic [7:0] c0, c1, r0, r1, r2);
        host_addr(c0); host_addr(c1); host_addr(r0); host_addr(r1); host_addr(r2);
    endtask

    task automatic host_data(logic [7:0] b);
        if (!ce_n && !m_busy && m_phase == 2) begin
            m_buf[m_col % 64] = b;
            m_col = clamp(m_col + 1);
        end
        strobe(1'b0, 1'b0, b);
    endtask

    task automatic host_read(string req);
        @(negedge clk);
        re_n = 1'b0;
        cyc(4);
        if (!ce_n && !m_busy) begin
            chk(req, "read byte", io_out, m_buf[m_col % 64]);
            chk(req, "drive enable during read", io_oe, 1);
            m_col = clamp(m_col + 1);
        end
        re_n = 1'b1;
        cyc(4);
    endtask

    task automatic wait_ready(string req);
        for (int i = 0; i < 400 && !rb; i++) cyc(1);
        m_busy = 0;
        chk(req, "busy clocks", low_cnt, exp_low);
        chk(req, "pending operation starts", exp_kind.size(), 0);
    endtask

    always @(posedge clk) begin
        re_b <= re_a;
        re_a <= re_n;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!rb) low_cnt++;
            if (op_valid) begin
                if (exp_kind.size() == 0) chk("R1", "unexpected operation start", 1, 0);
                else begin
                    chk("R1", "operation kind", op_kind, exp_kind.pop_front());
                    chk("R2", "operation row", op_row, exp_row.pop_front());
                end
            end
            // R6: drive enable follows select and the settled read strobe
            chk("R6", "drive enable", io_oe, (!ce_n && !re_b) ? 1 : 0);
        end
    end

    initial begin
        cyc(200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        ce_n  = 1'b0;
        cyc(3);
        chk("R11", "ready after reset", rb, 1);
        chk("R11", "no drive after reset", io_oe, 0);
        chk("R11", "no start after reset", op_valid, 0);

        // program: address with unused upper row bits, eight data bytes
        host_cmd(8'h80);
        host_addr5(8'h10, 8'h00, 8'h34, 8'h12, 8'hFF);
        for (int i = 0; i < 8; i++) host_data(8'(8'hA0 + i * 3));
        host_cmd(8'h10);
        wait_ready("R7");

        // read back: column high byte carries ignored bits, sixth address byte ignored
        host_cmd(8'h00);
        host_addr5(8'h10, 8'hF0, 8'h01, 8'h02, 8'h00);
        host_addr(8'h55);
        host_cmd(8'h30);
        wait_ready("R2");
        for (int i = 0; i < 8; i++) host_read("R5");

        // last columns of the page, program blocked by write protect
        host_cmd(8'h80);
        host_addr5(8'h3E, 8'h08, 8'h00, 8'h00, 8'h00);
        host_data(8'hA1); host_data(8'hB2); host_data(8'hC3);
        wp_n = 1'b0;
        host_cmd(8'h10);
        wait_ready("R8");
        host_cmd(8'h60);
        host_addr(8'h07); host_addr(8'h00); host_addr(8'h01);
        host_cmd(8'hD0);
        wait_ready("R8");
        // read still allowed, column beyond the page is clamped
        host_cmd(8'h00);
        host_addr5(8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        wait_ready("R8");
        host_read("R3"); host_read("R3");
        wp_n = 1'b1;
        host_cmd(8'h00);
        host_addr5(8'h3E, 8'h08, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        wait_ready("R4");
        host_read("R4"); host_read("R4"); host_read("R4");

        // erase with three row bytes
        host_cmd(8'h60);
        host_addr(8'h07); host_addr(8'h00); host_addr(8'h01);
        host_cmd(8'hD0);
        wait_ready("R2");

        // zero busy length
        busy_len = 16'd0;
        host_cmd(8'h00);
        host_addr5(8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        wait_ready("R7");
        busy_len = 16'd20;

        // confirm without setup
        host_cmd(8'h30);
        wait_ready("R1");

        // deselected strobes are ignored while ready
        host_cmd(8'h00);
        host_addr5(8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        wait_ready("R9");
        host_read("R9");
        ce_n = 1'b1;
        host_cmd(8'h00);
        host_addr5(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        host_read("R9");
        ce_n = 1'b0;
        cyc(2);
        host_read("R9");

        // deselect during busy does not shorten it
        busy_len = 16'd40;
        host_cmd(8'h00);
        host_addr5(8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        ce_n = 1'b1;
        wait_ready("R9");
        ce_n = 1'b0;
        cyc(2);

        // strobes during busy are dropped
        busy_len = 16'd60;
        host_cmd(8'h00);
        host_addr5(8'h12, 8'h00, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        host_addr(8'h00);
        host_addr(8'h00);
        host_read("R10");
        wait_ready("R10");
        host_read("R10");

        // reset command cuts a long busy short
        busy_len = 16'd200;
        host_cmd(8'h00);
        host_addr5(8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
        host_cmd(8'h30);
        host_cmd(8'hFF);
        for (int i = 0; i < 400 && !rb; i++) cyc(1);
        m_busy = 0;
        chk("R10", "busy seen before reset command", (low_cnt > 0) ? 1 : 0, 1);
        chk("R10", "reset command ends busy early", (low_cnt < 200) ? 1 : 0, 1);
        chk("R10", "pending operation starts", exp_kind.size(), 0);
        host_read("R10");
        host_cmd(8'h30);
        wait_ready("R10");

        cyc(10);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule